// File: doc/BRIEF.md
# Remappable Priority DMA Channel Arbiter

This block chooses which of twelve DMA channels may use a shared peripheral-side bus in the next cycle. The channel number sets priority, and channel 0 ranks highest. Each of the first eight channels has a writable 4-bit routing field. That field chooses which peripheral request line feeds the channel, so software sets a peripheral's rank by choosing the channel it sits on. The last four channels serve two memory-to-memory streams. Each stream owns a destination channel and a source channel, and their routing is fixed.

The grant is a registered one-hot vector that is recomputed on every clock. Each cycle in which a grant is held counts as one transfer. A 5-bit burst period lets a memory stream that wins the bus keep it for several transfers in a row, and the other stream is shut out for that time. A registered counter shows how many transfers are still left in the current burst. A registered readback port returns the routing field and the channel-type bit of any channel.

Top module: `dma_prio_arbiter`

## Requirements
- R1: After reset, `grant` is zero, `rr_count` is zero and every routing field of channels 0 to 7 reads zero.
- R2: `grant` is registered and follows the requests sampled at the previous rising edge. Exactly one bit is high when any channel request was present, and all bits are low when none was.
- R3: Among the channels that request, the lowest-numbered one wins: channel 0 highest, channel 11 lowest.
- R4: Channel c (0 to 7) requests when `periph_req[map[c]]` is high. Routing codes 0 to 7 select, in this order: parallel port, serial port 0 receive, serial port 0 transmit, serial port 1 receive, serial port 1 transmit, SPI, UART receive, UART transmit. Codes 8 to 15 attach no peripheral.
- R5: When two or more channels hold the same routing code, only the lowest-numbered of them sees that peripheral's request.
- R6: Channels 8 to 11 take `mdma_req[0]` to `mdma_req[3]`. In that order they are stream 0 destination, stream 0 source, stream 1 destination and stream 1 source. Routing writes with `cfg_sel` 8 to 15 change nothing.
- R7: One cycle after `rd_sel` is applied, `map_rd[4]` is the channel-type bit and `map_rd[3:0]` is the routing field. For channels 0 to 7 the type bit is 0 and the field is the stored code. For channels 8 to 11 the output reads 5'h10. For select values 12 to 15 it reads zero.
- R8: With a burst period of zero, stream 0 always goes ahead of stream 1 and `rr_count` stays zero.
- R9: With a burst period P greater than zero, a memory stream that newly wins keeps the grant for up to P consecutive transfers while it keeps requesting. `rr_count` reads P-1 down to 0 during those transfers. A new contest then prefers the stream that did not hold the last burst.
- R10: Any peripheral-channel request pre-empts a memory burst at the next transfer. `rr_count` then returns to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| periph_req | input | 8 | Request line per peripheral, indexed by routing code |
| mdma_req | input | 4 | Memory stream requests for channels 8 to 11 |
| cfg_we | input | 1 | Routing field write strobe |
| cfg_sel | input | 4 | Channel index for the write |
| cfg_wdata | input | 4 | Routing code to store |
| rr_we | input | 1 | Burst period write strobe |
| rr_wdata | input | 5 | New burst period |
| rd_sel | input | 4 | Channel index for readback |
| map_rd | output | 5 | {channel type, routing field} of `rd_sel`, registered |
| grant | output | 12 | One-hot registered grant |
| rr_count | output | 5 | Transfers remaining in the current burst |

## Verification
The bench builds the block with its default parameters: eight peripheral channels, four memory channels, 4-bit routing codes and a 5-bit burst period. This setting makes every routing code reachable, including the unattached codes 8 to 15 and the read-only writes to indices 8 to 15. A small burst period of 3 lets a full hold, the handover to the other stream and a peripheral pre-emption all happen within a few cycles. The reset value of the routing fields is all zero, so it also exercises the duplicate-routing rule with no setup.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int unsigned PERIPH_CH_D = 8;
  localparam int unsigned MDMA_CH_D   = 4;
  localparam int unsigned MAP_W_D     = 4;
  localparam int unsigned RR_W_D      = 5;
  typedef logic [MAP_W_D-1:0] route_code_t;
endpackage

// File: rtl/dma_map_regs.sv
module dma_map_regs #(
  parameter int unsigned PERIPH_CH = dma_arb_pkg::PERIPH_CH_D,
  parameter int unsigned MDMA_CH   = dma_arb_pkg::MDMA_CH_D,
  parameter int unsigned MAP_W     = dma_arb_pkg::MAP_W_D,
  localparam int unsigned CH       = PERIPH_CH + MDMA_CH,
  localparam int unsigned SEL_W    = $clog2(CH)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_we,
  input  logic [SEL_W-1:0]       cfg_sel,
  input  logic [MAP_W-1:0]       cfg_wdata,
  input  logic [SEL_W-1:0]       rd_sel,
  output logic [MAP_W:0]         map_rd,
  output logic [PERIPH_CH*MAP_W-1:0] map_flat
);
  logic [MAP_W-1:0] map_q [PERIPH_CH];

  for (genvar c = 0; c < PERIPH_CH; c++) begin : g_map
    always_ff @(posedge clk) begin
      if (rst) map_q[c] <= '0;
      else if (cfg_we && cfg_sel == SEL_W'(c)) map_q[c] <= cfg_wdata;
    end
    assign map_flat[c*MAP_W +: MAP_W] = map_q[c];
  end

  always_ff @(posedge clk) begin
    if (rst) map_rd <= '0;
    else if (rd_sel < SEL_W'(PERIPH_CH)) map_rd <= {1'b0, map_q[rd_sel[$clog2(PERIPH_CH)-1:0]]};
    else if (rd_sel < SEL_W'(CH)) map_rd <= {1'b1, {MAP_W{1'b0}}};
    else map_rd <= '0;
  end

  // R6: a write aimed at a fixed channel leaves every stored code untouched
  p_fixed_write_ignored_r6: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_sel >= SEL_W'(PERIPH_CH)) |=> (map_flat == $past(map_flat)));
endmodule

// File: rtl/dma_req_router.sv
module dma_req_router #(
  parameter int unsigned PERIPH_CH = dma_arb_pkg::PERIPH_CH_D,
  parameter int unsigned MAP_W     = dma_arb_pkg::MAP_W_D,
  localparam int unsigned IDX_W    = $clog2(PERIPH_CH)
) (
  input  logic [PERIPH_CH-1:0]       periph_req,
  input  logic [PERIPH_CH*MAP_W-1:0] map_flat,
  output logic [PERIPH_CH-1:0]       chan_req
);
  for (genvar c = 0; c < PERIPH_CH; c++) begin : g_route
    logic [MAP_W-1:0] code;
    logic             attached;
    logic             shadowed;
    assign code     = map_flat[c*MAP_W +: MAP_W];
    assign attached = (code < MAP_W'(PERIPH_CH));
    always_comb begin
      shadowed = 1'b0;
      for (int j = 0; j < c; j++) begin
        if (map_flat[j*MAP_W +: MAP_W] == code) shadowed = 1'b1;
      end
    end
    assign chan_req[c] = attached && !shadowed && periph_req[code[IDX_W-1:0]];
  end
endmodule

// File: rtl/dma_grant_engine.sv
module dma_grant_engine #(
  parameter int unsigned PERIPH_CH = dma_arb_pkg::PERIPH_CH_D,
  parameter int unsigned MDMA_CH   = dma_arb_pkg::MDMA_CH_D,
  parameter int unsigned RR_W      = dma_arb_pkg::RR_W_D,
  localparam int unsigned CH       = PERIPH_CH + MDMA_CH
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [CH-1:0]   chan_req,
  input  logic [RR_W-1:0] rr_period,
  output logic [CH-1:0]   grant,
  output logic [RR_W-1:0] rr_count
);
  logic [1:0]      sreq;
  logic            periph_any;
  logic            last_stream;
  logic [CH-1:0]   grant_d;
  logic [RR_W-1:0] cnt_d;
  logic            last_d;
  logic            win;
  logic [1:0]      sgrant;

  assign periph_any = |chan_req[PERIPH_CH-1:0];
  for (genvar s = 0; s < 2; s++) begin : g_stream
    assign sreq[s]   = |chan_req[PERIPH_CH+2*s +: 2];
    assign sgrant[s] = |grant[PERIPH_CH+2*s +: 2];
  end

  always_comb begin
    grant_d = '0;
    cnt_d   = '0;
    last_d  = last_stream;
    win     = 1'b0;
    if (periph_any) begin
      for (int i = PERIPH_CH-1; i >= 0; i--) begin
        if (chan_req[i]) grant_d = CH'(1) << i;
      end
    end else if (|sreq) begin
      if (rr_count != '0 && sreq[last_stream]) begin
        win   = last_stream;
        cnt_d = rr_count - 1'b1;
      end else begin
        if (rr_period == '0) win = !sreq[0];
        else win = sreq[!last_stream] ? !last_stream : last_stream;
        cnt_d = (rr_period == '0) ? '0 : rr_period - 1'b1;
      end
      last_d = win;
      if (chan_req[PERIPH_CH + 2*win]) grant_d = CH'(1) << (PERIPH_CH + 2*win);
      else grant_d = CH'(1) << (PERIPH_CH + 2*win + 1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant       <= '0;
      rr_count    <= '0;
      last_stream <= 1'b1;
    end else begin
      grant       <= grant_d;
      rr_count    <= cnt_d;
      last_stream <= last_d;
    end
  end

  // R2: never more than one grant bit
  p_grant_onehot_r2: assert property (@(posedge clk) disable iff (rst) $onehot0(grant));
  // R2: any request leads to a grant on the next edge
  p_req_granted_r2: assert property (@(posedge clk) disable iff (rst)
    (|chan_req) |=> (|grant));
  // R3: a grant never appears without a request one cycle earlier
  p_grant_has_req_r3: assert property (@(posedge clk) disable iff (rst)
    (|grant) |-> $past(|chan_req));
  // R10: peripheral requests always take the next transfer
  p_periph_first_r10: assert property (@(posedge clk) disable iff (rst)
    periph_any |=> (|grant[PERIPH_CH-1:0]) && rr_count == '0);
  // R9: an unfinished burst stays with its holder
  p_burst_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (rr_count != '0 && !periph_any && sreq[last_stream]) |=> sgrant[$past(last_stream)]);
endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter #(
  parameter int unsigned PERIPH_CH = dma_arb_pkg::PERIPH_CH_D,
  parameter int unsigned MDMA_CH   = dma_arb_pkg::MDMA_CH_D,
  parameter int unsigned MAP_W     = dma_arb_pkg::MAP_W_D,
  parameter int unsigned RR_W      = dma_arb_pkg::RR_W_D,
  localparam int unsigned CH       = PERIPH_CH + MDMA_CH,
  localparam int unsigned SEL_W    = $clog2(CH)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [PERIPH_CH-1:0] periph_req,
  input  logic [MDMA_CH-1:0]   mdma_req,
  input  logic                 cfg_we,
  input  logic [SEL_W-1:0]     cfg_sel,
  input  logic [MAP_W-1:0]     cfg_wdata,
  input  logic                 rr_we,
  input  logic [RR_W-1:0]      rr_wdata,
  input  logic [SEL_W-1:0]     rd_sel,
  output logic [MAP_W:0]       map_rd,
  output logic [CH-1:0]        grant,
  output logic [RR_W-1:0]      rr_count
);
  logic [PERIPH_CH*MAP_W-1:0] map_flat;
  logic [PERIPH_CH-1:0]       pchan_req;
  logic [RR_W-1:0]            rr_period;

  always_ff @(posedge clk) begin
    if (rst) rr_period <= '0;
    else if (rr_we) rr_period <= rr_wdata;
  end

  dma_map_regs #(.PERIPH_CH(PERIPH_CH), .MDMA_CH(MDMA_CH), .MAP_W(MAP_W)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .rd_sel(rd_sel), .map_rd(map_rd), .map_flat(map_flat));

  dma_req_router #(.PERIPH_CH(PERIPH_CH), .MAP_W(MAP_W)) u_route (
    .periph_req(periph_req), .map_flat(map_flat), .chan_req(pchan_req));

  dma_grant_engine #(.PERIPH_CH(PERIPH_CH), .MDMA_CH(MDMA_CH), .RR_W(RR_W)) u_eng (
    .clk(clk), .rst(rst), .chan_req({mdma_req, pchan_req}), .rr_period(rr_period),
    .grant(grant), .rr_count(rr_count));

  // R8: with no burst period the counter never leaves zero
  p_zero_period_r8: assert property (@(posedge clk) disable iff (rst)
    (rr_period == '0 && !rr_we) |=> rr_count == '0);
endmodule

// File: tb/test_dma_prio_arbiter.sv
`timescale 1ns/1ps
module test_dma_prio_arbiter;
  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  periph_req;
  logic [3:0]  mdma_req;
  logic        cfg_we;
  logic [3:0]  cfg_sel;
  logic [3:0]  cfg_wdata;
  logic        rr_we;
  logic [4:0]  rr_wdata;
  logic [3:0]  rd_sel;
  logic [4:0]  map_rd;
  logic [11:0] grant;
  logic [4:0]  rr_count;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dma_prio_arbiter i_dma_prio_arbiter (
    .clk(clk), .rst(rst), .periph_req(periph_req), .mdma_req(mdma_req),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .rr_we(rr_we), .rr_wdata(rr_wdata), .rd_sel(rd_sel),
    .map_rd(map_rd), .grant(grant), .rr_count(rr_count));

  // {periph_req, mdma_req, expected grant}, after channel c is routed to code 7-c
  localparam logic [23:0] VEC [8] = '{
    {8'h01, 4'h0, 12'h080}, {8'h80, 4'h0, 12'h001}, {8'h14, 4'h0, 12'h008},
    {8'h00, 4'hA, 12'h200}, {8'h00, 4'h8, 12'h800}, {8'h00, 4'hC, 12'h400},
    {8'h40, 4'hF, 12'h002}, {8'h00, 4'h0, 12'h000}};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; periph_req = '0; mdma_req = '0; cfg_we = 1'b0; cfg_sel = '0;
    cfg_wdata = '0; rr_we = 1'b0; rr_wdata = '0; rd_sel = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic wr_map(int ch, int code);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = 4'(ch); cfg_wdata = 4'(code);
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic rd_map(int ch, string req, logic [4:0] exp);
    @(negedge clk); rd_sel = 4'(ch);
    cyc();
    chk(req, 32'(map_rd), 32'(exp));
  endtask

  task automatic drive(logic [7:0] p, logic [3:0] m);
    @(negedge clk); periph_req = p; mdma_req = m;
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 grant", 32'(grant), 0);
    chk("R1 rr_count", 32'(rr_count), 0);
    rd_map(0, "R1 map0", 5'h00);
    rd_map(7, "R1 map7", 5'h00);
    rd_map(8, "R7 type ch8", 5'h10);
    rd_map(13, "R7 sel13", 5'h00);
    // R5: all channels share code 0, only channel 0 sees it
    drive(8'h01, 4'h0); cyc(); chk("R5 default dup", 32'(grant), 32'h001);
    drive(8'h02, 4'h0); cyc(); chk("R4 unmapped code", 32'(grant), 0);
    drive(8'h00, 4'h0); cyc();
    // route channel c to code 7-c, then walk the table (R2 R3 R4 R6 R8)
    for (int c = 0; c < 8; c++) wr_map(c, 7 - c);
    rd_map(3, "R7 map3", 5'h04);
    for (int i = 0; i < 8; i++) begin
      drive(VEC[i][23:16], VEC[i][15:12]);
      cyc();
      chk($sformatf("R3 R4 R6 vec%0d", i), 32'(grant), 32'(VEC[i][11:0]));
      chk($sformatf("R8 cnt vec%0d", i), 32'(rr_count), 0);
    end
    // R5 duplicate: channels 2 and 5 both code 3
    wr_map(2, 3); wr_map(5, 3);
    drive(8'h08, 4'h0); cyc(); chk("R5 dup lowest", 32'(grant), 32'h004);
    // R4 unattached code on channel 0 (code 9)
    wr_map(0, 9);
    drive(8'h80, 4'h0); cyc(); chk("R4 code9 detach", 32'(grant), 0);
    // R6 write to fixed channel ignored
    wr_map(9, 5);
    rd_map(9, "R6 fixed read", 5'h10);
    drive(8'h00, 4'h2); cyc(); chk("R6 ch9 still memory", 32'(grant), 32'h200);
    // R8 stream 0 ahead of stream 1 with zero period, repeatedly
    drive(8'h00, 4'h5); cyc(); chk("R8 s0 first", 32'(grant), 32'h100);
    cyc(); chk("R8 s0 again", 32'(grant), 32'h100);
    // R9 burst period 3
    do_reset();
    @(negedge clk); rr_we = 1'b1; rr_wdata = 5'd3;
    @(negedge clk); rr_we = 1'b0;
    drive(8'h00, 4'h5);
    cyc(); chk("R9 b1 grant", 32'(grant), 32'h100); chk("R9 b1 cnt", 32'(rr_count), 2);
    cyc(); chk("R9 b2 grant", 32'(grant), 32'h100); chk("R9 b2 cnt", 32'(rr_count), 1);
    cyc(); chk("R9 b3 grant", 32'(grant), 32'h100); chk("R9 b3 cnt", 32'(rr_count), 0);
    cyc(); chk("R9 handover", 32'(grant), 32'h400); chk("R9 reload", 32'(rr_count), 2);
    // R10 peripheral pre-empts (default routing: code 0 -> channel 0)
    drive(8'h01, 4'h5);
    cyc(); chk("R10 preempt", 32'(grant), 32'h001); chk("R10 cnt clear", 32'(rr_count), 0);
    drive(8'h00, 4'h5);
    cyc(); chk("R9 after preempt", 32'(grant), 32'h100); chk("R9 cnt after", 32'(rr_count), 2);
    drive(8'h00, 4'h0);
    cyc(); chk("R2 idle", 32'(grant), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule